// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital state machine that decides which operating mode a LIN bus interface is in. It has five modes: unpowered, pre-normal, normal, silent and sleep. It drives the control lines for the regulator, the transmit and receive paths, the slave termination and the bus driver. Its inputs are the enable and transmit-data pins from the host, a supply-good comparator, a regulator undervoltage flag, wake strobes from a separate wake detector, and a reset-hold flag from the external power-on reset logic.

The host picks the low-power mode with one gesture. It pulls enable low, and a fixed number of cycles later the transmit pin is sampled. A high level on the transmit pin gives silent mode and a low level gives sleep mode. A separate counter watches the transmit pin: if the pin is held dominant too long, the bus driver is forced off and stays off until the pin is released. All outputs come from registers, and the mode is held as a one-hot vector.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset the mode is unpowered and every control output is low. `mode_o` is one-hot: bit 0 unpowered, bit 1 pre-normal, bit 2 normal, bit 3 silent, bit 4 sleep.
- R2: In unpowered mode, a high `vs_ok_i` moves the block to pre-normal mode. Pre-normal has the regulator on at full tolerance, the termination on, and both data paths off.
- R3: In pre-normal mode, a high `en_i` moves the block to normal mode. Normal has the regulator, both data paths and the termination on.
- R4: A falling edge of `en_i` in normal mode opens a select window. If `en_i` is still low at the edge WIN_CYC clock edges after the one that saw the fall, and `txd_i` is high there, the block enters silent mode. Silent has the regulator on in low-tolerance setting and the data paths and termination off.
- R5: The same sequence with `txd_i` low at the sampling edge enters sleep mode, where every control output is low.
- R6: If `en_i` returns high before the window closes, the selection is cancelled and the block stays in normal mode.
- R7: A bus or local wake strobe in silent or sleep mode returns the block to pre-normal mode.
- R8: A regulator undervoltage in silent mode, or a low `vs_ok_i` in silent or sleep mode, forces pre-normal mode. A low `vs_ok_i` in pre-normal or normal mode returns the block to unpowered.
- R9: In silent mode a high `en_i` goes directly to normal mode. In sleep mode `en_i` has no effect.
- R10: While `por_hold_i` is high, mode changes driven by enable are refused. This covers pre-normal to normal, silent to normal, and the opening of a select window.
- R11: `drv_on_o` is high only in normal mode with `txd_i` low. It is forced low once `txd_i` has been low at DOM_CYC consecutive clock edges, and it stays low until an edge sees `txd_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Host enable pin |
| txd_i | input | 1 | Transmit data pin (low = dominant) |
| vs_ok_i | input | 1 | Supply-good comparator, hysteresis applied externally |
| vcc_uv_i | input | 1 | Regulator undervoltage flag |
| por_hold_i | input | 1 | High while the power-on reset output is held active |
| bus_wake_i | input | 1 | Remote wake strobe from the wake detector |
| local_wake_i | input | 1 | Local wake strobe from the wake detector |
| mode_o | output | 5 | One-hot current mode |
| reg_en_o | output | 1 | Regulator enable |
| reg_lowtol_o | output | 1 | Regulator low-tolerance select |
| tx_en_o | output | 1 | Transmit path enable |
| rx_en_o | output | 1 | Receive path enable |
| term_en_o | output | 1 | Slave termination enable |
| drv_on_o | output | 1 | Gated bus driver on |

## Verification
A wrong mode register shows at the ports one edge after the stimulus. The outputs are decoded from the next state and registered on the same edge, so `mode_o` and the five control lines change together and must agree with each other. Off-by-one errors in the select window show up as a silent or sleep entry one edge early or late, or as a cancelled selection that goes through anyway. These are caught by comparing the outputs with a bench model on every cycle. A timeout counter that clears or saturates wrongly shows on `drv_on_o` at edge DOM_CYC of a dominant run, or at the first edge after the transmit pin is released.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

  typedef enum logic [4:0] {
    M_UNPWR  = 5'b00001,
    M_PRE    = 5'b00010,
    M_NORM   = 5'b00100,
    M_SILENT = 5'b01000,
    M_SLEEP  = 5'b10000
  } mode_e;

  typedef struct packed {
    logic reg_en;
    logic lowtol;
    logic tx_en;
    logic rx_en;
    logic term_en;
  } mode_out_t;

  function automatic mode_out_t decode_mode(mode_e m);
    mode_out_t o;
    o = '0;
    unique case (m)
      M_PRE:    begin o.reg_en = 1'b1; o.term_en = 1'b1; end
      M_NORM:   begin o.reg_en = 1'b1; o.term_en = 1'b1; o.tx_en = 1'b1; o.rx_en = 1'b1; end
      M_SILENT: begin o.reg_en = 1'b1; o.lowtol = 1'b1; end
      default:  o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/lmc_sel_window.sv
module lmc_sel_window #(
  parameter int WIN_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic arm_i,
  output logic sel_o
);
  localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

  logic          en_q, act_q;
  logic [CW-1:0] cnt_q;
  logic          fall, last, start;

  assign fall  = en_q & ~en_i;
  assign last  = (cnt_q == CW'(WIN_CYC - 1));
  assign start = ~act_q & fall & arm_i;
  assign sel_o = act_q & arm_i & ~en_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q <= en_i;
      if (start) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end else if (act_q) begin
        // window closes on expiry, enable high, or loss of arming
        act_q <= arm_i & ~en_i & ~last;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_win_start_clean_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (act_q && cnt_q == '0));

endmodule

// File: rtl/lmc_dom_timer.sv
module lmc_dom_timer #(
  parameter int DOM_CYC = 4000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  output logic exp_d_o
);
  localparam int DW = $clog2(DOM_CYC + 1);
  localparam logic [DW-1:0] LIMIT = DW'(DOM_CYC);

  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (txd_i)               cnt_d = '0;
    else if (cnt_q == LIMIT) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  assign exp_d_o = (cnt_d == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_dom_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LIMIT && !txd_i) |=> (cnt_q == LIMIT));

endmodule

// File: rtl/lmc_mode_fsm.sv
module lmc_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       vs_ok_i,
  input  logic       vcc_uv_i,
  input  logic       por_hold_i,
  input  logic       bus_wake_i,
  input  logic       local_wake_i,
  input  logic       sel_i,
  input  logic       exp_d_i,
  output logic       arm_o,
  output logic [4:0] mode_o,
  output logic       reg_en_o,
  output logic       reg_lowtol_o,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       term_en_o,
  output logic       drv_on_o
);
  mode_e     state_q, state_d;
  mode_out_t out_q, out_d;
  logic      drv_q;
  logic      wake, en_go;

  assign wake  = bus_wake_i | local_wake_i;
  assign en_go = en_i & ~por_hold_i;
  assign arm_o = (state_q == M_NORM) & ~por_hold_i & vs_ok_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      M_UNPWR:  if (vs_ok_i) state_d = M_PRE;
      M_PRE:    if (!vs_ok_i) state_d = M_UNPWR;
                else if (en_go) state_d = M_NORM;
      M_NORM:   if (!vs_ok_i) state_d = M_UNPWR;
                else if (sel_i) state_d = txd_i ? M_SILENT : M_SLEEP;
      M_SILENT: if (!vs_ok_i || vcc_uv_i || wake) state_d = M_PRE;
                else if (en_go) state_d = M_NORM;
      M_SLEEP:  if (!vs_ok_i || wake) state_d = M_PRE;
      default:  state_d = M_UNPWR;
    endcase
  end

  assign out_d = decode_mode(state_d);

  // outputs registered from next state: no lag, no glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= M_UNPWR;
      out_q   <= '0;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      out_q   <= out_d;
      drv_q   <= out_d.tx_en & ~txd_i & ~exp_d_i;
    end
  end

  assign mode_o       = state_q;
  assign reg_en_o     = out_q.reg_en;
  assign reg_lowtol_o = out_q.lowtol;
  assign tx_en_o      = out_q.tx_en;
  assign rx_en_o      = out_q.rx_en;
  assign term_en_o    = out_q.term_en;
  assign drv_on_o     = drv_q;

  assert_mode_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(mode_o));
  assert_drv_norm_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_on_o |-> (tx_en_o && mode_o == M_NORM));
  assert_drv_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_i |=> !drv_on_o);
  assert_por_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_hold_i && state_q == M_PRE && vs_ok_i) |=> (state_q == M_PRE));
  assert_sleep_en_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_SLEEP && vs_ok_i && !wake) |=> (state_q == M_SLEEP));
  assert_wake_to_pre_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == M_SILENT || state_q == M_SLEEP) && wake) |=> (state_q == M_PRE));
  assert_en_high_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_NORM && en_i) |=> !(state_q == M_SILENT || state_q == M_SLEEP));
  assert_silent_outputs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_SILENT) |-> (reg_en_o && reg_lowtol_o && !tx_en_o && !rx_en_o && !term_en_o));

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl #(
  parameter int WIN_CYC = 4,
  parameter int DOM_CYC = 4000000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       vs_ok_i,
  input  logic       vcc_uv_i,
  input  logic       por_hold_i,
  input  logic       bus_wake_i,
  input  logic       local_wake_i,
  output logic [4:0] mode_o,
  output logic       reg_en_o,
  output logic       reg_lowtol_o,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       term_en_o,
  output logic       drv_on_o
);
  logic arm, sel, exp_d;

  lmc_sel_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .arm_i  (arm),
    .sel_o  (sel)
  );

  lmc_dom_timer #(.DOM_CYC(DOM_CYC)) u_dom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .txd_i   (txd_i),
    .exp_d_o (exp_d)
  );

  lmc_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .txd_i        (txd_i),
    .vs_ok_i      (vs_ok_i),
    .vcc_uv_i     (vcc_uv_i),
    .por_hold_i   (por_hold_i),
    .bus_wake_i   (bus_wake_i),
    .local_wake_i (local_wake_i),
    .sel_i        (sel),
    .exp_d_i      (exp_d),
    .arm_o        (arm),
    .mode_o       (mode_o),
    .reg_en_o     (reg_en_o),
    .reg_lowtol_o (reg_lowtol_o),
    .tx_en_o      (tx_en_o),
    .rx_en_o      (rx_en_o),
    .term_en_o    (term_en_o),
    .drv_on_o     (drv_on_o)
  );

endmodule

// File: tb/lin_mode_ctrl_tb_top.sv
module lin_mode_ctrl_tb_top;
  localparam int WIN = 4;
  localparam int DOM = 40;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 1'b0, txd = 1'b1, vs_ok = 1'b0, uv = 1'b0, por = 1'b0, bw = 1'b0, lw = 1'b0;
  logic [4:0] mode;
  logic reg_en, lowtol, tx_en, rx_en, term_en, drv_on;

  lin_mode_ctrl #(.WIN_CYC(WIN), .DOM_CYC(DOM)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .txd_i(txd), .vs_ok_i(vs_ok),
    .vcc_uv_i(uv), .por_hold_i(por), .bus_wake_i(bw), .local_wake_i(lw),
    .mode_o(mode), .reg_en_o(reg_en), .reg_lowtol_o(lowtol), .tx_en_o(tx_en),
    .rx_en_o(rx_en), .term_en_o(term_en), .drv_on_o(drv_on)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  string req = "R1";

  // behavioural model: mode 0 unpwr,1 pre,2 norm,3 silent,4 sleep
  int m_mode = 0, m_cnt = 0, m_low = 0, nm = 0;
  bit m_en_prev = 0, m_act = 0, m_drv = 0, arm = 0, fall = 0, sel = 0;

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_mode = 0; m_cnt = 0; m_low = 0; m_en_prev = 0; m_act = 0; m_drv = 0;
    end else begin
      arm  = (m_mode == 2) && !por && vs_ok;
      fall = m_en_prev && !en;
      sel  = m_act && arm && !en && (m_cnt == WIN - 1);
      nm = m_mode;
      case (m_mode)
        0: if (vs_ok) nm = 1;
        1: if (!vs_ok) nm = 0; else if (en && !por) nm = 2;
        2: if (!vs_ok) nm = 0; else if (sel) nm = txd ? 3 : 4;
        3: if (!vs_ok || uv || bw || lw) nm = 1; else if (en && !por) nm = 2;
        4: if (!vs_ok || bw || lw) nm = 1;
        default: nm = 0;
      endcase
      if (m_act) begin
        m_act = arm && !en && (m_cnt != WIN - 1);
        m_cnt++;
      end else if (fall && arm) begin
        m_act = 1; m_cnt = 0;
      end
      if (txd) m_low = 0; else if (m_low < DOM) m_low++;
      m_drv = (nm == 2) && !txd && (m_low < DOM);
      m_mode = nm;
      m_en_prev = en;
    end
    #2;
    cmp("mode_o", int'(mode), 1 << m_mode);
    cmp("reg_en_o", int'(reg_en), int'(m_mode >= 1 && m_mode <= 3));
    cmp("reg_lowtol_o", int'(lowtol), int'(m_mode == 3));
    cmp("tx_en_o", int'(tx_en), int'(m_mode == 2));
    cmp("rx_en_o", int'(rx_en), int'(m_mode == 2));
    cmp("term_en_o", int'(term_en), int'(m_mode == 1 || m_mode == 2));
    cmp("drv_on_o", int'(drv_on), int'(m_drv));
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_mode(int m, string r);
    req = r;
    cmp("mode point", int'(mode), 1 << m);
  endtask

  task automatic expect_drv(bit d, string r);
    req = r;
    cmp("drv point", int'(drv_on), int'(d));
  endtask

  task automatic to_silent();
    txd = 1'b1; en = 1'b0; wait_cyc(WIN + 2);
  endtask

  initial begin
    wait_cyc(3);
    // R1: reset state
    expect_mode(0, "R1");
    req = "R1"; cmp("outputs idle", int'({reg_en, lowtol, tx_en, rx_en, term_en, drv_on}), 0);
    rst_ni = 1'b1; wait_cyc(2);
    expect_mode(0, "R1");
    // R2: supply good
    vs_ok = 1'b1; wait_cyc(1);
    expect_mode(1, "R2");
    req = "R2"; cmp("pre outputs", int'({reg_en, lowtol, tx_en, rx_en, term_en}), 5'b10001);
    // R10: reset hold blocks enable
    por = 1'b1; en = 1'b1; wait_cyc(3);
    expect_mode(1, "R10");
    por = 1'b0; wait_cyc(1);
    expect_mode(2, "R3");
    // R11: dominant timeout
    txd = 1'b0; wait_cyc(10);
    expect_drv(1'b1, "R11");
    wait_cyc(35);
    expect_drv(1'b0, "R11");
    txd = 1'b1; wait_cyc(1);
    expect_drv(1'b0, "R11");
    txd = 1'b0; wait_cyc(1);
    expect_drv(1'b1, "R11");
    txd = 1'b1; wait_cyc(1);
    // R6: cancelled selection
    req = "R6"; en = 1'b0; wait_cyc(2); en = 1'b1; wait_cyc(6);
    expect_mode(2, "R6");
    // R10: window not opened under reset hold
    por = 1'b1; en = 1'b0; wait_cyc(WIN + 3);
    expect_mode(2, "R10");
    en = 1'b1; por = 1'b0; wait_cyc(1);
    // R4: silent
    req = "R4"; to_silent();
    expect_mode(3, "R4");
    // R10 then R9: silent to normal
    por = 1'b1; en = 1'b1; wait_cyc(3);
    expect_mode(3, "R10");
    por = 1'b0; wait_cyc(2);
    expect_mode(2, "R9");
    // R5: sleep
    req = "R5"; txd = 1'b0; en = 1'b0; wait_cyc(WIN + 2);
    expect_mode(4, "R5");
    // R9: enable ignored in sleep
    en = 1'b1; wait_cyc(3);
    expect_mode(4, "R9");
    en = 1'b0; txd = 1'b1; wait_cyc(1);
    // R7: bus wake from sleep
    bw = 1'b1; wait_cyc(1); bw = 1'b0;
    expect_mode(1, "R7");
    en = 1'b1; wait_cyc(1);
    expect_mode(2, "R3");
    to_silent();
    expect_mode(3, "R4");
    lw = 1'b1; wait_cyc(1); lw = 1'b0;
    expect_mode(1, "R7");
    // R8: undervoltage in silent
    en = 1'b1; wait_cyc(1);
    to_silent();
    uv = 1'b1; wait_cyc(1); uv = 1'b0;
    expect_mode(1, "R8");
    // R8: supply drop in sleep, then in pre-normal
    en = 1'b1; wait_cyc(1);
    req = "R8"; txd = 1'b0; en = 1'b0; wait_cyc(WIN + 2);
    expect_mode(4, "R5");
    txd = 1'b1; vs_ok = 1'b0; wait_cyc(1);
    expect_mode(1, "R8");
    wait_cyc(1);
    expect_mode(0, "R8");
    vs_ok = 1'b1; wait_cyc(2);
    expect_mode(1, "R2");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule